// File: doc/BRIEF.md
# Configuration Image Loader

This block moves a configuration image from a byte stream into the byte-wide programming port of a target device. The image begins with a 16-byte header. The first four header bytes hold the payload length, most significant byte first. The remaining twelve header bytes carry version, date and spare information; the loader consumes them and drops them. Once the header has been read, the loader pulses the target's reset and waits for it to settle. It then writes a single zero byte and waits again. After that it passes exactly the declared number of payload bytes to the target, one byte per accepted input transfer, and closes with five zero pad bytes.

In the cycle after the last pad byte, the loader samples the target's error line. If the line is low, a final wait follows and the loader then reports completion. If the line is high, the load is reported as failed. The interrupt-enable output drops when a load begins and only comes back after a successful load. Input transfers use a valid/ready handshake, and a last marker shows where the image ends. An image that ends before the header is complete, or before the declared payload has arrived, is reported as failed. A short header causes no reset and no write to the target. All wait lengths are parameters counted in clock cycles.

Top module: `cfg_loader`

## Requirements
- R1: After reset, busy, loadDone, loadFail, tgtReset, outStrobe and inReady are 0, and irqEnable is 1.
- R2: After an accepted start, inReady is 1 until 16 header bytes have been accepted. The first four bytes form the payload length, big-endian. No header byte appears on outStrobe.
- R3: After the header, tgtReset is 1 for RST_CYC cycles. Then come SETTLE_CYC quiet cycles, one cycle with outStrobe=1 and outData=0x00, and SETTLE_CYC quiet cycles again.
- R4: During the payload phase inReady is 1, and outStrobe equals inValid, with outData equal to inData. Exactly the declared number of bytes is forwarded, in order, and gaps in inValid stall the transfer.
- R5: After the last payload byte, outStrobe is 1 with outData=0x00 for exactly five consecutive cycles.
- R6: tgtErr is sampled in the cycle after the fifth pad byte. If it is 1, loadFail goes to 1 and busy to 0 in the next cycle, while loadDone and irqEnable stay 0.
- R7: If inLast arrives with any of header bytes 0 to 14, loadFail goes to 1 in the next cycle, and no tgtReset and no outStrobe occur.
- R8: If inLast arrives before the declared payload count is reached (including on header byte 15 when the length is nonzero), loadFail goes to 1 in the next cycle, with no pad bytes.
- R9: After a clean check cycle, busy stays 1 for FINAL_CYC cycles. Then loadDone and irqEnable go to 1, and loadDone and loadFail are never 1 together.
- R10: irqEnable is 0 from the cycle after an accepted start until loadDone, and it stays 0 after a failure.
- R11: start has no effect while busy is 1.
- R12: A length of zero goes from the second settle wait straight to the five pad bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load when not busy |
| inData | input | 8 | Image byte |
| inValid | input | 1 | Image byte present |
| inLast | input | 1 | Marks the final byte of the image |
| inReady | output | 1 | Loader accepts the image byte |
| outData | output | 8 | Byte to the target's programming port |
| outStrobe | output | 1 | Write strobe for outData |
| tgtReset | output | 1 | Reset pulse to the target |
| tgtErr | input | 1 | Target error flag, sampled after the pad bytes |
| irqEnable | output | 1 | Interrupt enable, low during a load |
| busy | output | 1 | Load in progress |
| loadDone | output | 1 | Last load succeeded |
| loadFail | output | 1 | Last load failed |

## Verification
Two of the loader's functions can apply to the same accepted byte: the end-of-image marker and reaching the declared byte count. When they coincide, the load must end normally. When the marker comes first, the load must fail. The bench provokes both orders. It puts inLast on the final counted payload byte, and on header byte 15 with a length of zero, and expects the pad bytes to follow. It also puts inLast on an earlier byte and expects a failure in the next cycle with no pad. In every cycle it compares the strobe, data and status against a model that walks the expected phases. It also pulses start inside stall cycles, where a start would clash with an active load, and expects the trace to stay the same.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_RST, ST_SET1, ST_DUMMY, ST_SET2,
    ST_PAY, ST_PAD, ST_CHK, ST_FIN, ST_DONE, ST_FAIL
  } ldState_e;

  typedef enum logic [1:0] {
    W_RST, W_SETTLE, W_PAD, W_FINAL
  } waitSel_e;

  typedef struct packed {
    logic     clrHdr;
    logic     hdrTake;
    logic     payTake;
    logic     waitLoad;
    waitSel_e waitSel;
    logic     waitDec;
    logic     drivePay;
    logic     driveZero;
  } ldCtl_t;

endpackage

// File: rtl/cfg_loader_dp.sv
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HDR_BYTES  = 16,
  parameter int LEN_BYTES  = 4,
  parameter int PAD_BYTES  = 5,
  parameter int RST_CYC    = 16,
  parameter int SETTLE_CYC = 64,
  parameter int FINAL_CYC  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldCtl_t            ctl,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic [DATA_W-1:0] outData,
  output logic              outStrobe,
  output logic              hdrLast,
  output logic              lenZero,
  output logic              remainOne,
  output logic              waitZero
);
  localparam int LEN_W   = LEN_BYTES * DATA_W;
  localparam int HIDX_W  = $clog2(HDR_BYTES);
  localparam int MAX_A   = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int MAX_B   = (PAD_BYTES > FINAL_CYC) ? PAD_BYTES : FINAL_CYC;
  localparam int WAIT_MX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(WAIT_MX + 1);

  logic [HIDX_W-1:0] hdrIdx;
  logic [LEN_W-1:0]  lenReg;
  logic [CNT_W-1:0]  waitCnt;
  logic [CNT_W-1:0]  waitInit;

  // header byte index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            hdrIdx <= '0;
    else if (ctl.clrHdr)  hdrIdx <= '0;
    else if (ctl.hdrTake) hdrIdx <= hdrIdx + 1'b1;
  end

  // length register: filled big-endian from the header, then counts down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      lenReg <= '0;
    else if (ctl.clrHdr)
      lenReg <= '0;
    else if (ctl.hdrTake && hdrIdx < HIDX_W'(LEN_BYTES))
      lenReg <= {lenReg[LEN_W-DATA_W-1:0], inData};
    else if (ctl.payTake)
      lenReg <= lenReg - 1'b1;
  end

  always_comb begin
    case (ctl.waitSel)
      W_RST:    waitInit = CNT_W'(RST_CYC - 1);
      W_SETTLE: waitInit = CNT_W'(SETTLE_CYC - 1);
      W_PAD:    waitInit = CNT_W'(PAD_BYTES - 1);
      default:  waitInit = CNT_W'(FINAL_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             waitCnt <= '0;
    else if (ctl.waitLoad) waitCnt <= waitInit;
    else if (ctl.waitDec)  waitCnt <= waitCnt - 1'b1;
  end

  assign hdrLast   = (hdrIdx == HIDX_W'(HDR_BYTES - 1));
  assign lenZero   = (lenReg == '0);
  assign remainOne = (lenReg == LEN_W'(1));
  assign waitZero  = (waitCnt == '0);

  assign outStrobe = ctl.driveZero | (ctl.drivePay & inValid);
  assign outData   = ctl.drivePay ? inData : '0;

endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   inValid,
  input  logic   inLast,
  input  logic   tgtErr,
  input  logic   hdrLast,
  input  logic   lenZero,
  input  logic   remainOne,
  input  logic   waitZero,
  output ldCtl_t ctl,
  output logic   inReady,
  output logic   tgtReset,
  output logic   busy,
  output logic   loadDone,
  output logic   loadFail,
  output logic   irqEnable
);
  ldState_e state, nextState;
  logic     restLike;
  logic     startTake;
  logic     irqReg;

  assign restLike  = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL);
  assign startTake = restLike && start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    ctl.waitSel = W_RST;
    inReady   = 1'b0;
    tgtReset  = 1'b0;
    case (state)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          ctl.clrHdr = 1'b1;
          nextState  = ST_HDR;
        end
      end
      ST_HDR: begin
        inReady = 1'b1;
        if (inValid) begin
          ctl.hdrTake = 1'b1;
          if (hdrLast) begin
            if (inLast && !lenZero) nextState = ST_FAIL;
            else begin
              ctl.waitLoad = 1'b1;
              ctl.waitSel  = W_RST;
              nextState    = ST_RST;
            end
          end else if (inLast) begin
            nextState = ST_FAIL;
          end
        end
      end
      ST_RST: begin
        tgtReset = 1'b1;
        if (waitZero) begin
          ctl.waitLoad = 1'b1;
          ctl.waitSel  = W_SETTLE;
          nextState    = ST_SET1;
        end else ctl.waitDec = 1'b1;
      end
      ST_SET1: begin
        if (waitZero) nextState = ST_DUMMY;
        else          ctl.waitDec = 1'b1;
      end
      ST_DUMMY: begin
        ctl.driveZero = 1'b1;
        ctl.waitLoad  = 1'b1;
        ctl.waitSel   = W_SETTLE;
        nextState     = ST_SET2;
      end
      ST_SET2: begin
        if (waitZero) begin
          if (lenZero) begin
            ctl.waitLoad = 1'b1;
            ctl.waitSel  = W_PAD;
            nextState    = ST_PAD;
          end else nextState = ST_PAY;
        end else ctl.waitDec = 1'b1;
      end
      ST_PAY: begin
        inReady      = 1'b1;
        ctl.drivePay = 1'b1;
        if (inValid) begin
          ctl.payTake = 1'b1;
          if (remainOne) begin
            ctl.waitLoad = 1'b1;
            ctl.waitSel  = W_PAD;
            nextState    = ST_PAD;
          end else if (inLast) begin
            nextState = ST_FAIL;
          end
        end
      end
      ST_PAD: begin
        ctl.driveZero = 1'b1;
        if (waitZero) nextState = ST_CHK;
        else          ctl.waitDec = 1'b1;
      end
      ST_CHK: begin
        if (tgtErr) nextState = ST_FAIL;
        else begin
          ctl.waitLoad = 1'b1;
          ctl.waitSel  = W_FINAL;
          nextState    = ST_FIN;
        end
      end
      ST_FIN: begin
        if (waitZero) nextState = ST_DONE;
        else          ctl.waitDec = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // interrupt enable: dropped on start, restored only on success
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      irqReg <= 1'b1;
    else if (startTake)
      irqReg <= 1'b0;
    else if (state == ST_FIN && nextState == ST_DONE)
      irqReg <= 1'b1;
  end

  assign irqEnable = irqReg;
  assign busy      = !restLike;
  assign loadDone  = (state == ST_DONE);
  assign loadFail  = (state == ST_FAIL);

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HDR_BYTES  = 16,
  parameter int LEN_BYTES  = 4,
  parameter int PAD_BYTES  = 5,
  parameter int RST_CYC    = 16,
  parameter int SETTLE_CYC = 64,
  parameter int FINAL_CYC  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outStrobe,
  output logic              tgtReset,
  input  logic              tgtErr,
  output logic              irqEnable,
  output logic              busy,
  output logic              loadDone,
  output logic              loadFail
);
  ldCtl_t ctl;
  logic   hdrLast, lenZero, remainOne, waitZero;

  cfg_loader_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .inLast(inLast),
    .tgtErr(tgtErr), .hdrLast(hdrLast), .lenZero(lenZero), .remainOne(remainOne),
    .waitZero(waitZero), .ctl(ctl), .inReady(inReady), .tgtReset(tgtReset),
    .busy(busy), .loadDone(loadDone), .loadFail(loadFail), .irqEnable(irqEnable)
  );

  cfg_loader_dp #(
    .DATA_W(DATA_W), .HDR_BYTES(HDR_BYTES), .LEN_BYTES(LEN_BYTES),
    .PAD_BYTES(PAD_BYTES), .RST_CYC(RST_CYC), .SETTLE_CYC(SETTLE_CYC),
    .FINAL_CYC(FINAL_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .inValid(inValid),
    .outData(outData), .outStrobe(outStrobe), .hdrLast(hdrLast),
    .lenZero(lenZero), .remainOne(remainOne), .waitZero(waitZero)
  );

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic clk,
  input logic rstN,
  input logic inReady,
  input logic outStrobe,
  input logic tgtReset,
  input logic irqEnable,
  input logic busy,
  input logic loadDone,
  input logic loadFail
);
  p_strobe_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    outStrobe |-> busy);

  p_ready_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> busy);

  p_reset_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    tgtReset |-> (!outStrobe && !inReady));

  p_irq_low_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !irqEnable);

  p_done_fail_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(loadDone && loadFail));

  p_done_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadDone) |-> irqEnable);

  p_fail_no_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    loadFail |-> !irqEnable);
endmodule

bind cfg_loader cfg_loader_chk u_chk (.*);

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;
  localparam int PERIOD = 10;
  localparam int RST_C  = 3;
  localparam int SET_C  = 4;
  localparam int FIN_C  = 5;
  localparam int PADN   = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, inValid = 1'b0, inLast = 1'b0, tgtErr = 1'b0;
  logic [7:0] inData = '0;
  logic inReady, outStrobe, tgtReset, irqEnable, busy, loadDone, loadFail;
  logic [7:0] outData;

  int nChecks = 0;
  int nFails  = 0;
  byte unsigned img[$];

  always #(PERIOD/2) clk = ~clk;

  cfg_loader #(.RST_CYC(RST_C), .SETTLE_CYC(SET_C), .FINAL_CYC(FIN_C)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .inData(inData), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .outData(outData), .outStrobe(outStrobe),
    .tgtReset(tgtReset), .tgtErr(tgtErr), .irqEnable(irqEnable), .busy(busy),
    .loadDone(loadDone), .loadFail(loadFail)
  );

  task automatic chk(string req, bit eBusy, bit eRdy, bit eRst, bit eStb,
                     logic [7:0] eDat, bit eDone, bit eFail, bit eIrq);
    nChecks++;
    if (busy !== eBusy || inReady !== eRdy || tgtReset !== eRst ||
        outStrobe !== eStb || (eStb && outData !== eDat) ||
        loadDone !== eDone || loadFail !== eFail || irqEnable !== eIrq) begin
      nFails++;
      $display("FAIL %s @%0t: got busy=%0b rdy=%0b rst=%0b stb=%0b dat=%02h done=%0b fail=%0b irq=%0b, expected %0b %0b %0b %0b %02h %0b %0b %0b",
               req, $time, busy, inReady, tgtReset, outStrobe, outData, loadDone,
               loadFail, irqEnable, eBusy, eRdy, eRst, eStb, eDat, eDone, eFail, eIrq);
    end
  endtask

  // step to the next cycle, drive inputs, let combinational outputs settle
  task automatic drv(bit s, bit v, logic [7:0] d, bit l, bit e);
    @(negedge clk);
    start = s; inValid = v; inData = d; inLast = l; tgtErr = e;
    #1;
  endtask

  // behavioural model: walks the load phases and compares every cycle
  task automatic runImage(int lastAt, bit gaps, bit tErr, bit poke);
    int n;
    longint len;
    n = img.size();
    len = (n >= 4) ? ((longint'(img[0]) << 24) | (longint'(img[1]) << 16) |
                      (longint'(img[2]) << 8) | longint'(img[3])) : 0;
    drv(1, 0, 8'h00, 0, 0);
    for (int i = 0; i < 16 && i < n; i++) begin
      if (gaps) begin
        drv(poke, 0, 8'h00, 0, 0);
        chk("R2 R11 header stall", 1, 1, 0, 0, 8'h00, 0, 0, 0);
      end
      drv(0, 1, img[i], i == lastAt, 0);
      chk("R2 R10 header byte", 1, 1, 0, 0, 8'h00, 0, 0, 0);
      if (i == lastAt && i < 15) begin
        drv(0, 0, 8'h00, 0, 0);
        chk("R7 short image", 0, 0, 0, 0, 8'h00, 0, 1, 0);
        return;
      end
    end
    if (lastAt == 15 && len != 0) begin
      drv(0, 0, 8'h00, 0, 0);
      chk("R8 ended at header", 0, 0, 0, 0, 8'h00, 0, 1, 0);
      return;
    end
    for (int c = 0; c < RST_C; c++) begin
      drv(poke, 0, 8'h00, 0, 0);
      chk("R3 reset pulse", 1, 0, 1, 0, 8'h00, 0, 0, 0);
    end
    for (int c = 0; c < SET_C; c++) begin
      drv(0, 0, 8'h00, 0, 0);
      chk("R3 settle one", 1, 0, 0, 0, 8'h00, 0, 0, 0);
    end
    drv(0, 0, 8'h00, 0, 0);
    chk("R3 dummy byte", 1, 0, 0, 1, 8'h00, 0, 0, 0);
    for (int c = 0; c < SET_C; c++) begin
      drv(poke, 0, 8'h00, 0, 0);
      chk("R3 R12 settle two", 1, 0, 0, 0, 8'h00, 0, 0, 0);
    end
    for (longint k = 0; k < len; k++) begin
      int idx;
      idx = 16 + int'(k);
      if (gaps && (k % 2 == 0)) begin
        drv(poke, 0, 8'hEE, 0, 0);
        chk("R4 R11 payload stall", 1, 1, 0, 0, 8'h00, 0, 0, 0);
      end
      drv(0, 1, img[idx], idx == lastAt, 0);
      chk("R4 payload byte", 1, 1, 0, 1, img[idx], 0, 0, 0);
      if (idx == lastAt && k < len - 1) begin
        drv(0, 0, 8'h00, 0, 0);
        chk("R8 truncated payload", 0, 0, 0, 0, 8'h00, 0, 1, 0);
        return;
      end
    end
    for (int c = 0; c < PADN; c++) begin
      drv(0, 0, 8'h00, 0, 0);
      chk("R5 R12 pad byte", 1, 0, 0, 1, 8'h00, 0, 0, 0);
    end
    drv(0, 0, 8'h00, 0, tErr);
    chk("R6 check cycle", 1, 0, 0, 0, 8'h00, 0, 0, 0);
    if (tErr) begin
      drv(0, 0, 8'h00, 0, 0);
      chk("R6 R10 target error", 0, 0, 0, 0, 8'h00, 0, 1, 0);
      return;
    end
    for (int c = 0; c < FIN_C; c++) begin
      drv(0, 0, 8'h00, 0, 0);
      chk("R9 final wait", 1, 0, 0, 0, 8'h00, 0, 0, 0);
    end
    drv(0, 0, 8'h00, 0, 0);
    chk("R9 R10 done", 0, 0, 0, 0, 8'h00, 1, 0, 1);
  endtask

  task automatic build(int len, int given);
    img.delete();
    img.push_back(8'((len >> 24) & 255));
    img.push_back(8'((len >> 16) & 255));
    img.push_back(8'((len >> 8) & 255));
    img.push_back(8'(len & 255));
    for (int i = 4; i < 16; i++) img.push_back(8'(8'hA0 + i));
    for (int k = 0; k < given; k++) img.push_back(8'((8'h31 + k * 7) & 255));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 reset state", 0, 0, 0, 0, 8'h00, 0, 0, 1);

    build(6, 6);            runImage(21, 0, 0, 0);   // plain success
    build(5, 5);            runImage(20, 1, 0, 1);   // stalls with start pokes
    build(3, 3);            runImage(18, 0, 1, 0);   // target reports error
    build(3, 0);            img = img[0:9];
                            runImage(9, 0, 0, 0);    // short header
    build(8, 4);            runImage(19, 1, 0, 0);   // truncated payload
    build(0, 0);            runImage(15, 0, 0, 0);   // zero length
    build(258, 258);        runImage(273, 0, 0, 0);  // big-endian length

    drv(0, 0, 8'h00, 0, 0);
    chk("R9 idle after done", 0, 0, 0, 0, 8'h00, 1, 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: run did not finish, got hang, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule